// File: doc/BRIEF.md
# Posted Column-Write Buffer with Deferred Retire

This block sits between a column command decoder and a sense-amplifier data array. A write command addressed to this device does not go straight to the array: its data unit (two lanes, A and B, of eight bytes each, nine bits per byte by default) is parked in a single-entry buffer together with its bank and column address. The entry is written to the array later, when a column command arrives that is allowed to move it. A per-byte mask that arrives with that later command selects which bytes are actually written.

Whether a command may move the entry depends on its type and on whether it targets this device. Reads aimed at this device never move the entry. Such a read is compared against the buffered bank and column, and on a match the buffered data is returned for substitution. The block also produces the bank precharge requests that a write-with-precharge, a read-with-precharge or a precharge command implies. The precharge for a buffered write-with-precharge is issued only after that entry has been written.

Top module: `wbuf_retire_top`

## Requirements
- R1: A write command (`cmd_op`=1) with `cmd_self`=1 stores `wr_data`, `cmd_bank` and `cmd_col` in the buffer. These values appear unchanged on `ret_data`, `ret_bank` and `ret_col` when the entry is later retired.
- R2: With the buffer full, a command to another device (`cmd_self`=0) retires the entry if it is a no-op (0), a write (1) or a read (2). A command to this device retires the entry if it is a no-op (0), a write (1) or a precharge (3). The retire is shown by `ret_en` high for the one cycle after the command's clock edge. A write to another device stores nothing.
- R3: A read (2) to this device never retires the entry, and neither does a precharge (3) to another device. The entry stays buffered for a later command.
- R4: `ret_be` bit i enables byte i, where 1 means write and 0 means keep. Bits 7..0 come from `mask_a` bits 7..0 and bits 15..8 come from `mask_b` bits 7..0, both sampled with the retiring command when `mask_valid`=1. With `mask_valid`=0 every bit of `ret_be` is 1.
- R5: An entry stored by a write with `cmd_pre`=1 raises `pre_req` bit [its bank] in the cycle after its retire, and not earlier.
- R6: A precharge (3) to this device retires a full buffer first. It then raises `pre_req` bit [`cmd_bank`] two cycles after its clock edge, whether or not the buffer held an entry. Two precharges that fall due together both appear in `pre_req`.
- R7: A write to this device while the buffer is full retires the old entry, using that command's mask, in the same cycle as it stores the new entry.
- R8: A read to this device whose bank and column match the buffered entry raises `rd_hit` with `rd_data` equal to the buffered data in the cycle after the command's edge. A read that misses, or a read with the buffer empty, leaves `rd_hit` low.
- R9: After reset the buffer is empty and `ret_en`, `pre_req` and `rd_hit` are all zero.
- R10: A read with `cmd_pre`=1 to this device raises `pre_req` bit [`cmd_bank`] two cycles after its edge and does not retire the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded column command is present |
| cmd_op | input | 2 | 0 no-op, 1 write, 2 read, 3 precharge |
| cmd_pre | input | 1 | Precharge after write or read |
| cmd_self | input | 1 | Command targets this device |
| cmd_bank | input | 5 | Bank address |
| cmd_col | input | 7 | Column address |
| wr_data | input | 144 | Write data unit, lane A in the low 72 bits |
| mask_valid | input | 1 | A mask word accompanies this command |
| mask_a | input | 8 | Lane A byte mask |
| mask_b | input | 8 | Lane B byte mask |
| ret_en | output | 1 | Array write strobe for the retired entry |
| ret_bank | output | 5 | Retired bank |
| ret_col | output | 7 | Retired column |
| ret_data | output | 144 | Retired data |
| ret_be | output | 16 | Per-byte write enables |
| pre_req | output | 32 | One bit per bank to precharge |
| rd_hit | output | 1 | Read matched the buffered entry |
| rd_data | output | 144 | Buffered data for the matching read |

## Verification
A wrong occupancy bit shows up at the next qualifying command as a missing or spurious `ret_en` one cycle after its edge. The same fault can show up on a matching read as a wrong `rd_hit`. A lost precharge flag or a corrupted stored bank shows on `pre_req` exactly two cycles after the retiring command, so each scenario samples retire outputs and precharge outputs at those two fixed points. Mask routing faults appear as a wrong `ret_be` pattern on the very retire they affect, which asymmetric lane masks expose.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [1:0] {
      OP_NOP  = 2'd0,
      OP_WR   = 2'd1,
      OP_RD   = 2'd2,
      OP_PREC = 2'd3
   } wb_op_e;
endpackage

// File: rtl/wbuf_retire_ctl.sv
module wbuf_retire_ctl
   import wbuf_pkg::*;
#(
   parameter int BANK_W = 5,
   parameter int COL_W  = 7
) (
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic              cmd_pre,
   input  logic              cmd_self,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic              full,
   input  logic [BANK_W-1:0] ent_bank,
   input  logic [COL_W-1:0]  ent_col,
   output logic              retire,
   output logic              capture,
   output logic              pre_cmd,
   output logic              rd_match
);
   wb_op_e op;
   logic   is_nop, is_wr, is_rd, is_prec, allowed;

   always_comb begin
      op      = wb_op_e'(cmd_op);
      is_nop  = (op == OP_NOP);
      is_wr   = (op == OP_WR);
      is_rd   = (op == OP_RD);
      is_prec = (op == OP_PREC);
      // same device: reads keep the entry; other device: precharge does not touch it
      allowed  = cmd_self ? (is_nop | is_wr | is_prec) : (is_nop | is_wr | is_rd);
      retire   = cmd_valid & full & allowed;
      capture  = cmd_valid & cmd_self & is_wr;
      pre_cmd  = cmd_valid & cmd_self & (is_prec | (is_rd & cmd_pre));
      rd_match = cmd_valid & cmd_self & is_rd & full &
                 (cmd_bank == ent_bank) & (cmd_col == ent_col);
   end
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
   parameter int BANK_W = 5,
   parameter int COL_W  = 7,
   parameter int DATA_W = 144
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              capture,
   input  logic              in_pre,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [COL_W-1:0]  in_col,
   input  logic [DATA_W-1:0] in_data,
   output logic              full,
   output logic              ent_pre,
   output logic [BANK_W-1:0] ent_bank,
   output logic [COL_W-1:0]  ent_col,
   output logic [DATA_W-1:0] ent_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full     <= 1'b0;
         ent_pre  <= 1'b0;
         ent_bank <= '0;
         ent_col  <= '0;
         ent_data <= '0;
      end else begin
         if (capture) begin
            full     <= 1'b1;
            ent_pre  <= in_pre;
            ent_bank <= in_bank;
            ent_col  <= in_col;
            ent_data <= in_data;
         end else if (retire) begin
            full     <= 1'b0;
            ent_pre  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wbuf_mask_expand.sv
module wbuf_mask_expand #(
   parameter int LANE_BYTES = 8
) (
   input  logic                    mask_valid,
   input  logic [LANE_BYTES-1:0]   mask_a,
   input  logic [LANE_BYTES-1:0]   mask_b,
   output logic [2*LANE_BYTES-1:0] be
);
   for (genvar i = 0; i < LANE_BYTES; i++) begin : g_lane
      assign be[i]            = mask_valid ? mask_a[i] : 1'b1;
      assign be[LANE_BYTES+i] = mask_valid ? mask_b[i] : 1'b1;
   end
endmodule

// File: rtl/wbuf_pre_seq.sv
module wbuf_pre_seq #(
   parameter int NBANK  = 32,
   parameter int BANK_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              ent_pre,
   input  logic [BANK_W-1:0] ent_bank,
   input  logic              pre_cmd,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic [NBANK-1:0]  pre_req
);
   logic [NBANK-1:0] stage_d, stage_q;

   always_comb begin
      stage_d = '0;
      if (retire && ent_pre) stage_d[ent_bank] = 1'b1;
      if (pre_cmd)           stage_d[cmd_bank] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         pre_req <= '0;
      end else begin
         stage_q <= stage_d;
         pre_req <= stage_q;
      end
   end
endmodule

// File: rtl/wbuf_retire_top.sv
module wbuf_retire_top #(
   parameter int BYTE_W     = 9,
   parameter int LANE_BYTES = 8,
   parameter int NBANK      = 32,
   parameter int NCOL       = 128,
   parameter bit FWD_EN     = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cmd_valid,
   input  logic [1:0]                           cmd_op,
   input  logic                                 cmd_pre,
   input  logic                                 cmd_self,
   input  logic [$clog2(NBANK)-1:0]             cmd_bank,
   input  logic [$clog2(NCOL)-1:0]              cmd_col,
   input  logic [2*LANE_BYTES*BYTE_W-1:0]       wr_data,
   input  logic                                 mask_valid,
   input  logic [LANE_BYTES-1:0]                mask_a,
   input  logic [LANE_BYTES-1:0]                mask_b,
   output logic                                 ret_en,
   output logic [$clog2(NBANK)-1:0]             ret_bank,
   output logic [$clog2(NCOL)-1:0]              ret_col,
   output logic [2*LANE_BYTES*BYTE_W-1:0]       ret_data,
   output logic [2*LANE_BYTES-1:0]              ret_be,
   output logic [NBANK-1:0]                     pre_req,
   output logic                                 rd_hit,
   output logic [2*LANE_BYTES*BYTE_W-1:0]       rd_data
);
   localparam int BANK_W = $clog2(NBANK);
   localparam int COL_W  = $clog2(NCOL);
   localparam int BE_W   = 2 * LANE_BYTES;
   localparam int DATA_W = BE_W * BYTE_W;

   if (BYTE_W != 8 && BYTE_W != 9) begin : g_bad_byte
      $error("BYTE_W must be 8 or 9");
   end
   if (LANE_BYTES < 1) begin : g_bad_lane
      $error("LANE_BYTES must be at least 1");
   end
   if ((1 << BANK_W) != NBANK || (1 << COL_W) != NCOL) begin : g_bad_pow2
      $error("NBANK and NCOL must be powers of two");
   end

   logic              full_q, ent_pre;
   logic [BANK_W-1:0] ent_bank;
   logic [COL_W-1:0]  ent_col;
   logic [DATA_W-1:0] ent_data;
   logic              retire, capture, pre_cmd, rd_match;
   logic [BE_W-1:0]   be_now;

   wbuf_retire_ctl #(.BANK_W(BANK_W), .COL_W(COL_W)) u_ctl (
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pre(cmd_pre),
      .cmd_self(cmd_self), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
      .full(full_q), .ent_bank(ent_bank), .ent_col(ent_col),
      .retire(retire), .capture(capture), .pre_cmd(pre_cmd),
      .rd_match(rd_match)
   );

   wbuf_entry #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .retire(retire), .capture(capture),
      .in_pre(cmd_pre), .in_bank(cmd_bank), .in_col(cmd_col),
      .in_data(wr_data), .full(full_q), .ent_pre(ent_pre),
      .ent_bank(ent_bank), .ent_col(ent_col), .ent_data(ent_data)
   );

   wbuf_mask_expand #(.LANE_BYTES(LANE_BYTES)) u_mask (
      .mask_valid(mask_valid), .mask_a(mask_a), .mask_b(mask_b), .be(be_now)
   );

   wbuf_pre_seq #(.NBANK(NBANK), .BANK_W(BANK_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .retire(retire), .ent_pre(ent_pre),
      .ent_bank(ent_bank), .pre_cmd(pre_cmd), .cmd_bank(cmd_bank),
      .pre_req(pre_req)
   );

   // retire port: the entry as it stood before this edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_en   <= 1'b0;
         ret_bank <= '0;
         ret_col  <= '0;
         ret_data <= '0;
         ret_be   <= '0;
      end else begin
         ret_en <= retire;
         if (retire) begin
            ret_bank <= ent_bank;
            ret_col  <= ent_col;
            ret_data <= ent_data;
            ret_be   <= be_now;
         end
      end
   end

   if (FWD_EN) begin : g_fwd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_hit  <= 1'b0;
            rd_data <= '0;
         end else begin
            rd_hit <= rd_match;
            if (rd_match) rd_data <= ent_data;
         end
      end
   end else begin : g_nofwd
      assign rd_hit  = 1'b0;
      assign rd_data = '0;
   end
endmodule

// File: rtl/wbuf_retire_chk.sv
module wbuf_retire_chk #(
   parameter int NBANK  = 32,
   parameter int BANK_W = 5,
   parameter int BE_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              cmd_self,
   input logic              mask_valid,
   input logic              full_q,
   input logic              ret_en,
   input logic [BE_W-1:0]   ret_be,
   input logic [NBANK-1:0]  pre_req,
   input logic              rd_hit
);
   // R3: same-device read leaves the entry in place
   p_rd_self_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2 && cmd_self) |=> !ret_en);

   // R2: a retire always stems from a command one edge earlier
   p_retire_has_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |-> $past(cmd_valid));

   // R4: absent mask writes every byte
   p_nomask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !$past(mask_valid)) |-> (&ret_be));

   // R6: at most two precharges fall due together, and only from a command two edges back
   p_pre_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pre_req) <= 2);
   p_pre_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req != '0) |-> $past(cmd_valid, 2));

   // R7: same-device write onto a full buffer retires and stays full
   p_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd1 && cmd_self && full_q) |=> (ret_en && full_q));

   // R8: a hit answers a same-device read only
   p_hit_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> $past(cmd_valid && cmd_op == 2'd2 && cmd_self));
endmodule

bind wbuf_retire_top wbuf_retire_chk #(.NBANK(NBANK), .BANK_W(BANK_W), .BE_W(BE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_self(cmd_self), .mask_valid(mask_valid), .full_q(full_q),
   .ret_en(ret_en), .ret_be(ret_be), .pre_req(pre_req), .rd_hit(rd_hit)
);

// File: tb/wbuf_retire_top_tb.sv
module wbuf_retire_top_tb;
   localparam int DW = 144;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = '0;
   logic          cmd_pre = 1'b0;
   logic          cmd_self = 1'b0;
   logic [4:0]    cmd_bank = '0;
   logic [6:0]    cmd_col = '0;
   logic [DW-1:0] wr_data = '0;
   logic          mask_valid = 1'b0;
   logic [7:0]    mask_a = '0, mask_b = '0;
   logic          ret_en, rd_hit;
   logic [4:0]    ret_bank;
   logic [6:0]    ret_col;
   logic [DW-1:0] ret_data, rd_data;
   logic [15:0]   ret_be;
   logic [31:0]   pre_req;

   int errors = 0, checks = 0;

   // snapshots: s1 one cycle after the command edge, s2 one cycle later
   logic          s_ret, s_hit;
   logic [4:0]    s_bank;
   logic [6:0]    s_col;
   logic [DW-1:0] s_data, s_rdat;
   logic [15:0]   s_be;
   logic [31:0]   s_pre1, s_pre2;

   wbuf_retire_top u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_pre(cmd_pre), .cmd_self(cmd_self), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col), .wr_data(wr_data), .mask_valid(mask_valid),
      .mask_a(mask_a), .mask_b(mask_b), .ret_en(ret_en), .ret_bank(ret_bank),
      .ret_col(ret_col), .ret_data(ret_data), .ret_be(ret_be),
      .pre_req(pre_req), .rd_hit(rd_hit), .rd_data(rd_data)
   );

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [15:0] s);
      return {9{s}};
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // one command, then snapshots and idle spacing of at least 8 cycles
   task automatic send(input logic [1:0] op, input logic pre, input logic self,
                       input logic [4:0] bank, input logic [6:0] col,
                       input logic [DW-1:0] d, input logic mv,
                       input logic [7:0] ma, input logic [7:0] mb);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_pre = pre; cmd_self = self;
      cmd_bank = bank; cmd_col = col; wr_data = d;
      mask_valid = mv; mask_a = ma; mask_b = mb;
      @(negedge clk);
      cmd_valid = 1'b0; mask_valid = 1'b0; cmd_pre = 1'b0;
      s_ret = ret_en; s_bank = ret_bank; s_col = ret_col; s_data = ret_data;
      s_be = ret_be; s_hit = rd_hit; s_rdat = rd_data; s_pre1 = pre_req;
      @(negedge clk);
      s_pre2 = pre_req;
      repeat (7) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R9 ret_en", DW'(ret_en), '0);
      chk("R9 pre_req", DW'(pre_req), '0);
      chk("R9 rd_hit", DW'(rd_hit), '0);
   endtask

   task automatic t_capture_nop_self;
      send(2'd1, 0, 1, 5'd3, 7'd5, pat(16'hA1B2), 0, 0, 0);
      chk("R9 empty buffer no retire on first write", DW'(s_ret), '0);
      send(2'd0, 0, 1, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R2 nop self retires", DW'(s_ret), 1);
      chk("R1 bank", DW'(s_bank), 3);
      chk("R1 col", DW'(s_col), 5);
      chk("R1 data", s_data, pat(16'hA1B2));
      chk("R4 default mask", DW'(s_be), 16'hFFFF);
   endtask

   task automatic t_read_blocks;
      send(2'd1, 0, 1, 5'd7, 7'd9, pat(16'h5EED), 0, 0, 0);
      send(2'd2, 0, 1, 5'd1, 7'd2, '0, 0, 0, 0);
      chk("R3 read self no retire", DW'(s_ret), '0);
      chk("R8 miss no hit", DW'(s_hit), '0);
      send(2'd2, 0, 1, 5'd7, 7'd9, '0, 0, 0, 0);
      chk("R8 hit", DW'(s_hit), 1);
      chk("R8 hit data", s_rdat, pat(16'h5EED));
      chk("R3 hit read no retire", DW'(s_ret), '0);
      send(2'd3, 0, 0, 5'd2, 7'd0, '0, 0, 0, 0);
      chk("R3 precharge other no retire", DW'(s_ret), '0);
      chk("R3 precharge other no pre", DW'(s_pre2), '0);
      send(2'd2, 0, 0, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R2 read other retires", DW'(s_ret), 1);
      chk("R2 read other bank", DW'(s_bank), 7);
      chk("R2 read other col", DW'(s_col), 9);
      chk("R2 read other no hit", DW'(s_hit), '0);
   endtask

   task automatic t_mask;
      send(2'd1, 0, 1, 5'd2, 7'd1, pat(16'h1234), 0, 0, 0);
      send(2'd0, 0, 0, 5'd0, 7'd0, '0, 1, 8'h5A, 8'hC3);
      chk("R2 nop other retires", DW'(s_ret), 1);
      chk("R4 lane masks", DW'(s_be), 16'hC35A);
   endtask

   task automatic t_write_full;
      send(2'd1, 0, 1, 5'd4, 7'd10, pat(16'hEEEE), 0, 0, 0);
      send(2'd1, 0, 1, 5'd6, 7'd11, pat(16'hF00D), 1, 8'h0F, 8'hF0);
      chk("R7 old retires", DW'(s_ret), 1);
      chk("R7 old bank", DW'(s_bank), 4);
      chk("R7 old data", s_data, pat(16'hEEEE));
      chk("R7 mask of writer", DW'(s_be), 16'hF00F);
      send(2'd0, 0, 1, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R7 new entry kept", DW'(s_ret), 1);
      chk("R7 new col", DW'(s_col), 11);
      chk("R7 new data", s_data, pat(16'hF00D));
   endtask

   task automatic t_write_other;
      send(2'd1, 0, 1, 5'd30, 7'd127, pat(16'h0BAD), 0, 0, 0);
      send(2'd1, 0, 0, 5'd0, 7'd0, pat(16'h9999), 0, 0, 0);
      chk("R2 write other retires", DW'(s_ret), 1);
      chk("R2 write other col", DW'(s_col), 127);
      send(2'd0, 0, 1, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R2 write other stores nothing", DW'(s_ret), '0);
   endtask

   task automatic t_wra;
      send(2'd1, 1, 1, 5'd12, 7'd3, pat(16'h7777), 0, 0, 0);
      chk("R5 no pre at capture", DW'(s_pre2), '0);
      send(2'd0, 0, 1, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R5 retire", DW'(s_ret), 1);
      chk("R5 no pre with retire", DW'(s_pre1), '0);
      chk("R5 pre after retire", DW'(s_pre2), 32'h1 << 12);
   endtask

   task automatic t_prec;
      send(2'd1, 0, 1, 5'd20, 7'd0, pat(16'h2020), 0, 0, 0);
      send(2'd3, 0, 1, 5'd21, 7'd0, '0, 0, 0, 0);
      chk("R6 retire first", DW'(s_ret), 1);
      chk("R6 retire bank", DW'(s_bank), 20);
      chk("R6 pre cmd bank", DW'(s_pre2), 32'h1 << 21);
      send(2'd3, 0, 1, 5'd9, 7'd0, '0, 0, 0, 0);
      chk("R6 empty no retire", DW'(s_ret), '0);
      chk("R6 empty still pre", DW'(s_pre2), 32'h1 << 9);
      send(2'd1, 1, 1, 5'd5, 7'd0, pat(16'h5555), 0, 0, 0);
      send(2'd3, 0, 1, 5'd8, 7'd0, '0, 0, 0, 0);
      chk("R6 R5 two precharges", DW'(s_pre2), (32'h1 << 5) | (32'h1 << 8));
   endtask

   task automatic t_rda;
      send(2'd1, 0, 1, 5'd1, 7'd1, pat(16'h3131), 0, 0, 0);
      send(2'd2, 1, 1, 5'd15, 7'd4, '0, 0, 0, 0);
      chk("R10 no retire", DW'(s_ret), '0);
      chk("R10 pre bank", DW'(s_pre2), 32'h1 << 15);
      send(2'd0, 0, 1, 5'd0, 7'd0, '0, 0, 0, 0);
      chk("R10 entry survived", s_data, pat(16'h3131));
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_capture_nop_self();
      t_read_blocks();
      t_mask();
      t_write_full();
      t_write_other();
      t_wra();
      t_prec();
      t_rda();
      summary();
   end
endmodule